// File: doc/BRIEF.md
# Software-Refilled Address Translation Buffer

This block is a small fully associative translation cache. It maps a 32-bit virtual address, qualified by an 8-bit address-space identifier (ASID), to a 32-bit physical address. Apart from a current-ASID register, it is the only translation hardware in the path. It never walks page tables. When it cannot translate an address, it raises an exception, and a software handler loads the missing entry through a dedicated write port.

Each lookup request carries a virtual address and an access kind: fetch, load or store. One cycle later the block returns one of two results:

- the physical address together with a flag that marks the frame as uncached, or
- one of three exception codes.

When an exception is raised, the faulting virtual address is latched for the handler to read. If several entries match the same address, the lowest-indexed entry is used and a sticky status bit is raised.

Top module: `tlb_xlate`

## Requirements
- R1: The low 12 bits of the virtual address are not translated. On a successful access, `rsp_paddr` is the selected entry's 20-bit frame number placed above those 12 bits.
- R2: An entry matches when it has been installed since reset, its page number equals `req_vaddr[31:12]`, and either its ASID equals the current ASID or its global bit is set.
- R3: When no entry matches, `rsp_exc` is 1 (refill), and `rsp_paddr` and `rsp_uncached` are 0.
- R4: When the matching entry has its valid bit at 0, `rsp_exc` is 2 (invalid). This applies to stores as well, so code 2 outranks code 3.
- R5: A store (`req_kind` = 2) to a valid matching entry whose dirty (write-enable) bit is 0 gives `rsp_exc` = 3 (modified). A fetch (0) or a load (1) to the same entry succeeds.
- R6: Every access that faults copies its virtual address into `bad_vaddr`. An access that succeeds leaves `bad_vaddr` unchanged. Reset clears `bad_vaddr` to 0.
- R7: On a successful access, `rsp_uncached` equals the entry's no-cache bit. It is 1 when the memory system must neither look up nor fill the cache.
- R8: A request sampled at a rising edge produces a response that is valid from that edge until the next one: `rsp_valid` is 1. A cycle with no request gives `rsp_valid` = 0 and `rsp_exc` = 0.
- R9: An entry write takes effect at the edge where it is sampled. A lookup sampled at the same edge still sees the old contents.
- R10: When more than one entry matches, the lowest index supplies the result. `multi_hit` then goes to 1 and stays at 1 until reset.
- R11: After reset, every lookup misses, `rsp_valid` is 0 and `multi_hit` is 0.
- R12: `asid_wr_en` loads `asid_wr_data` into the current-ASID register at the next edge. A lookup sampled at that same edge uses the previous ASID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| asid_wr_en | input | 1 | Load the current-ASID register |
| asid_wr_data | input | 8 | New current ASID |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 4 | Entry slot to write |
| wr_vpn | input | 20 | Virtual page number |
| wr_asid | input | 8 | Entry ASID |
| wr_global | input | 1 | Global bit: ASID is ignored when matching |
| wr_pfn | input | 20 | Physical frame number |
| wr_nocache | input | 1 | Frame is uncached |
| wr_dirty | input | 1 | Frame is writable |
| wr_valid | input | 1 | Entry valid bit |
| rsp_valid | output | 1 | Response strobe |
| rsp_paddr | output | 32 | Translated address; 0 on a fault |
| rsp_uncached | output | 1 | Bypass the cache for this access |
| rsp_exc | output | 2 | 0 none, 1 refill, 2 invalid, 3 modified |
| bad_vaddr | output | 32 | Last faulting virtual address |
| multi_hit | output | 1 | Sticky: an access matched more than one entry |

## Verification
Two pairs of events can land in the same cycle, and each is provoked on purpose.

- Entry write and lookup. The bench raises an entry write and a lookup of that same page together. The lookup must report a refill, because the write is not yet visible. The very next lookup of that page must hit with the new frame number.
- ASID change and lookup. The bench changes the current ASID in the same cycle as a lookup. The lookup must be judged against the old ASID. A repeat of the lookup afterwards must follow the new one.

In both cases the checks compare the exception code and the physical address against values worked out from the entry contents that the bench itself wrote.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_LOAD  = 2'd1,
      ACC_STORE = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_kind_e;

   typedef enum logic [1:0] {
      EXC_NONE     = 2'd0,
      EXC_REFILL   = 2'd1,
      EXC_INVALID  = 2'd2,
      EXC_MODIFIED = 2'd3
   } exc_code_e;

   localparam int SEL_CHAIN = 0;
   localparam int SEL_ISOLATE = 1;

endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 20,
   parameter int ASID_W  = 8,
   parameter int PFN_W   = 20,
   parameter int IDX_W   = $clog2(ENTRIES)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [IDX_W-1:0]         wr_idx,
   input  logic [VPN_W-1:0]         wr_vpn,
   input  logic [ASID_W-1:0]        wr_asid,
   input  logic                     wr_global,
   input  logic [PFN_W-1:0]         wr_pfn,
   input  logic                     wr_nocache,
   input  logic                     wr_dirty,
   input  logic                     wr_valid,
   input  logic [VPN_W-1:0]         lk_vpn,
   input  logic [ASID_W-1:0]        lk_asid,
   output logic [ENTRIES-1:0]       hit_vec,
   output logic [ENTRIES*PFN_W-1:0] pfn_flat,
   output logic [ENTRIES-1:0]       nocache_vec,
   output logic [ENTRIES-1:0]       dirty_vec,
   output logic [ENTRIES-1:0]       valid_vec
);

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      logic [VPN_W-1:0]  vpn_q;
      logic [ASID_W-1:0] asid_q;
      logic [PFN_W-1:0]  pfn_q;
      logic              glob_q;
      logic              nc_q;
      logic              dirty_q;
      logic              valid_q;
      logic              inst_q;
      logic              sel_w;
      logic              vpn_eq;
      logic              asid_ok;

      assign sel_w = wr_en && (wr_idx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vpn_q   <= '0;
            asid_q  <= '0;
            pfn_q   <= '0;
            glob_q  <= 1'b0;
            nc_q    <= 1'b0;
            dirty_q <= 1'b0;
            valid_q <= 1'b0;
            inst_q  <= 1'b0;
         end else if (sel_w) begin
            vpn_q   <= wr_vpn;
            asid_q  <= wr_asid;
            pfn_q   <= wr_pfn;
            glob_q  <= wr_global;
            nc_q    <= wr_nocache;
            dirty_q <= wr_dirty;
            valid_q <= wr_valid;
            inst_q  <= 1'b1;
         end
      end

      assign vpn_eq  = (vpn_q == lk_vpn);
      assign asid_ok = glob_q || (asid_q == lk_asid);

      assign hit_vec[i]                   = inst_q && vpn_eq && asid_ok;
      assign pfn_flat[i*PFN_W +: PFN_W]   = pfn_q;
      assign nocache_vec[i]               = nc_q;
      assign dirty_vec[i]                 = dirty_q;
      assign valid_vec[i]                 = valid_q;
   end

endmodule

// File: rtl/tlb_hit_select.sv
module tlb_hit_select #(
   parameter int ENTRIES   = 16,
   parameter int PFN_W     = 20,
   parameter int SEL_STYLE = tlb_pkg::SEL_CHAIN
) (
   input  logic [ENTRIES-1:0]       hit_vec,
   input  logic [ENTRIES*PFN_W-1:0] pfn_flat,
   input  logic [ENTRIES-1:0]       nocache_vec,
   input  logic [ENTRIES-1:0]       dirty_vec,
   input  logic [ENTRIES-1:0]       valid_vec,
   output logic                     any_hit,
   output logic                     multi,
   output logic [PFN_W-1:0]         sel_pfn,
   output logic                     sel_nocache,
   output logic                     sel_dirty,
   output logic                     sel_valid
);

   assign any_hit = |hit_vec;
   assign multi   = |(hit_vec & (hit_vec - ENTRIES'(1)));

   if (SEL_STYLE == tlb_pkg::SEL_CHAIN) begin : g_chain
      always_comb begin
         sel_pfn     = '0;
         sel_nocache = 1'b0;
         sel_dirty   = 1'b0;
         sel_valid   = 1'b0;
         for (int k = ENTRIES - 1; k >= 0; k--) begin
            if (hit_vec[k]) begin
               sel_pfn     = pfn_flat[k*PFN_W +: PFN_W];
               sel_nocache = nocache_vec[k];
               sel_dirty   = dirty_vec[k];
               sel_valid   = valid_vec[k];
            end
         end
      end
   end else begin : g_isolate
      logic [ENTRIES-1:0] first_hit;
      assign first_hit = hit_vec & ~(hit_vec - ENTRIES'(1));

      always_comb begin
         sel_pfn     = '0;
         sel_nocache = 1'b0;
         sel_dirty   = 1'b0;
         sel_valid   = 1'b0;
         for (int k = 0; k < ENTRIES; k++) begin
            sel_pfn     = sel_pfn | ({PFN_W{first_hit[k]}} & pfn_flat[k*PFN_W +: PFN_W]);
            sel_nocache = sel_nocache | (first_hit[k] & nocache_vec[k]);
            sel_dirty   = sel_dirty | (first_hit[k] & dirty_vec[k]);
            sel_valid   = sel_valid | (first_hit[k] & valid_vec[k]);
         end
      end
   end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
   parameter int VA_W      = 32,
   parameter int PA_W      = 32,
   parameter int OFF_W     = 12,
   parameter int ASID_W    = 8,
   parameter int ENTRIES   = 16,
   parameter int SEL_STYLE = tlb_pkg::SEL_CHAIN,
   parameter int VPN_W     = VA_W - OFF_W,
   parameter int PFN_W     = PA_W - OFF_W,
   parameter int IDX_W     = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [VA_W-1:0]   req_vaddr,
   input  logic [1:0]        req_kind,
   input  logic              asid_wr_en,
   input  logic [ASID_W-1:0] asid_wr_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [VPN_W-1:0]  wr_vpn,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic              wr_global,
   input  logic [PFN_W-1:0]  wr_pfn,
   input  logic              wr_nocache,
   input  logic              wr_dirty,
   input  logic              wr_valid,
   output logic              rsp_valid,
   output logic [PA_W-1:0]   rsp_paddr,
   output logic              rsp_uncached,
   output logic [1:0]        rsp_exc,
   output logic [VA_W-1:0]   bad_vaddr,
   output logic              multi_hit
);
   import tlb_pkg::*;

   if (OFF_W < 1 || OFF_W >= VA_W || OFF_W >= PA_W) begin : g_bad_off
      $error("tlb_xlate: page offset width must be below both address widths");
   end
   if (ENTRIES < 2) begin : g_bad_depth
      $error("tlb_xlate: at least two entries are required");
   end
   if (SEL_STYLE != SEL_CHAIN && SEL_STYLE != SEL_ISOLATE) begin : g_bad_sel
      $error("tlb_xlate: unknown selector style");
   end

   logic [ASID_W-1:0]        cur_asid_q;
   logic [ENTRIES-1:0]       hit_vec;
   logic [ENTRIES*PFN_W-1:0] pfn_flat;
   logic [ENTRIES-1:0]       nc_vec;
   logic [ENTRIES-1:0]       dirty_vec;
   logic [ENTRIES-1:0]       valid_vec;
   logic                     any_hit;
   logic                     multi;
   logic [PFN_W-1:0]         sel_pfn;
   logic                     sel_nc;
   logic                     sel_dirty;
   logic                     sel_valid;
   exc_code_e                exc_d;
   logic [PA_W-1:0]          paddr_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cur_asid_q <= '0;
      else if (asid_wr_en) cur_asid_q <= asid_wr_data;
   end

   tlb_entry_array #(
      .ENTRIES (ENTRIES),
      .VPN_W   (VPN_W),
      .ASID_W  (ASID_W),
      .PFN_W   (PFN_W),
      .IDX_W   (IDX_W)
   ) u_array (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_idx      (wr_idx),
      .wr_vpn      (wr_vpn),
      .wr_asid     (wr_asid),
      .wr_global   (wr_global),
      .wr_pfn      (wr_pfn),
      .wr_nocache  (wr_nocache),
      .wr_dirty    (wr_dirty),
      .wr_valid    (wr_valid),
      .lk_vpn      (req_vaddr[VA_W-1:OFF_W]),
      .lk_asid     (cur_asid_q),
      .hit_vec     (hit_vec),
      .pfn_flat    (pfn_flat),
      .nocache_vec (nc_vec),
      .dirty_vec   (dirty_vec),
      .valid_vec   (valid_vec)
   );

   tlb_hit_select #(
      .ENTRIES   (ENTRIES),
      .PFN_W     (PFN_W),
      .SEL_STYLE (SEL_STYLE)
   ) u_select (
      .hit_vec     (hit_vec),
      .pfn_flat    (pfn_flat),
      .nocache_vec (nc_vec),
      .dirty_vec   (dirty_vec),
      .valid_vec   (valid_vec),
      .any_hit     (any_hit),
      .multi       (multi),
      .sel_pfn     (sel_pfn),
      .sel_nocache (sel_nc),
      .sel_dirty   (sel_dirty),
      .sel_valid   (sel_valid)
   );

   always_comb begin
      if (!any_hit)
         exc_d = EXC_REFILL;
      else if (!sel_valid)
         exc_d = EXC_INVALID;
      else if (req_kind == ACC_STORE && !sel_dirty)
         exc_d = EXC_MODIFIED;
      else
         exc_d = EXC_NONE;
   end

   assign paddr_d = {sel_pfn, req_vaddr[OFF_W-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_exc      <= EXC_NONE;
         rsp_paddr    <= '0;
         rsp_uncached <= 1'b0;
         bad_vaddr    <= '0;
         multi_hit    <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_exc      <= exc_d;
            rsp_paddr    <= (exc_d == EXC_NONE) ? paddr_d : '0;
            rsp_uncached <= (exc_d == EXC_NONE) && sel_nc;
            if (exc_d != EXC_NONE) bad_vaddr <= req_vaddr;
            if (multi)             multi_hit <= 1'b1;
         end else begin
            rsp_exc      <= EXC_NONE;
            rsp_paddr    <= '0;
            rsp_uncached <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
   parameter int VA_W  = 32,
   parameter int PA_W  = 32,
   parameter int OFF_W = 12
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic [VA_W-1:0] req_vaddr,
   input logic [1:0]      req_kind,
   input logic            rsp_valid,
   input logic [PA_W-1:0] rsp_paddr,
   input logic            rsp_uncached,
   input logic [1:0]      rsp_exc,
   input logic [VA_W-1:0] bad_vaddr,
   input logic            multi_hit
);

   assert_rsp_follows_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && rsp_exc == 2'd0));

   assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && rst_n) |=> (rsp_exc != 2'd0 ||
                                rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));

   assert_fault_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_exc != 2'd0) |-> (rsp_paddr == '0 && !rsp_uncached));

   assert_modified_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (rsp_exc != 2'd3 || $past(req_kind) == 2'd2));

   assert_bad_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (rsp_exc == 2'd0 || bad_vaddr == $past(req_vaddr)));

   assert_bad_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(bad_vaddr));

   assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      multi_hit |=> multi_hit);

endmodule

bind tlb_xlate tlb_xlate_chk #(
   .VA_W  (VA_W),
   .PA_W  (PA_W),
   .OFF_W (OFF_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_vaddr    (req_vaddr),
   .req_kind     (req_kind),
   .rsp_valid    (rsp_valid),
   .rsp_paddr    (rsp_paddr),
   .rsp_uncached (rsp_uncached),
   .rsp_exc      (rsp_exc),
   .bad_vaddr    (bad_vaddr),
   .multi_hit    (multi_hit)
);

// File: tb/tlb_xlate_tb.sv
`timescale 1ns/1ps
module tlb_xlate_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic [1:0]  req_kind = '0;
   logic        asid_wr_en = 1'b0;
   logic [7:0]  asid_wr_data = '0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_idx = '0;
   logic [19:0] wr_vpn = '0;
   logic [7:0]  wr_asid = '0;
   logic        wr_global = 1'b0;
   logic [19:0] wr_pfn = '0;
   logic        wr_nocache = 1'b0;
   logic        wr_dirty = 1'b0;
   logic        wr_valid = 1'b0;
   logic        rsp_valid;
   logic [31:0] rsp_paddr;
   logic        rsp_uncached;
   logic [1:0]  rsp_exc;
   logic [31:0] bad_vaddr;
   logic        multi_hit;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   tlb_xlate u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
      .req_kind(req_kind), .asid_wr_en(asid_wr_en), .asid_wr_data(asid_wr_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_asid(wr_asid),
      .wr_global(wr_global), .wr_pfn(wr_pfn), .wr_nocache(wr_nocache),
      .wr_dirty(wr_dirty), .wr_valid(wr_valid), .rsp_valid(rsp_valid),
      .rsp_paddr(rsp_paddr), .rsp_uncached(rsp_uncached), .rsp_exc(rsp_exc),
      .bad_vaddr(bad_vaddr), .multi_hit(multi_hit)
   );

   // vector: vaddr(32) kind(2) exp_exc(2) exp_paddr(32) exp_uncached(1)
   localparam int NV = 8;
   localparam logic [68:0] VECS [NV] = '{
      {32'h0001_0ABC, 2'd1, 2'd0, 32'h8001_0ABC, 1'b0},  // R1 R2 load hit
      {32'h0001_0FFF, 2'd2, 2'd0, 32'h8001_0FFF, 1'b0},  // R5 store to writable
      {32'h0002_0123, 2'd0, 2'd0, 32'h8002_0123, 1'b1},  // R2 global, R7 uncached
      {32'h0002_0123, 2'd2, 2'd3, 32'h0000_0000, 1'b0},  // R5 store to read-only
      {32'h0003_0000, 2'd1, 2'd2, 32'h0000_0000, 1'b0},  // R4 invalid
      {32'h0003_0000, 2'd2, 2'd2, 32'h0000_0000, 1'b0},  // R4 invalid beats modified
      {32'h0004_0555, 2'd1, 2'd1, 32'h0000_0000, 1'b0},  // R2 ASID mismatch misses
      {32'h1234_5678, 2'd0, 2'd1, 32'h0000_0000, 1'b0}   // R3 no entry
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic write_entry(input logic [3:0] idx, input logic [19:0] vpn,
                              input logic [7:0] asid, input logic g,
                              input logic [19:0] pfn, input logic nc,
                              input logic d, input logic v);
      wr_en = 1'b1; wr_idx = idx; wr_vpn = vpn; wr_asid = asid; wr_global = g;
      wr_pfn = pfn; wr_nocache = nc; wr_dirty = d; wr_valid = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_asid(input logic [7:0] a);
      asid_wr_en = 1'b1; asid_wr_data = a;
      @(negedge clk);
      asid_wr_en = 1'b0;
   endtask

   task automatic lookup(input logic [31:0] va, input logic [1:0] kind);
      req_valid = 1'b1; req_vaddr = va; req_kind = kind;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 R6 reset state
      check("R11 rsp_valid after reset", 32'(rsp_valid), 32'd0);
      check("R11 multi_hit after reset", 32'(multi_hit), 32'd0);
      check("R6 bad_vaddr after reset", bad_vaddr, 32'd0);
      lookup(32'h0000_0000, 2'd1);
      check("R11 lookup after reset misses", 32'(rsp_exc), 32'd1);
      check("R3 refill gives zero address", rsp_paddr, 32'd0);

      set_asid(8'd5);
      write_entry(4'd0, 20'h00010, 8'd5, 1'b0, 20'h80010, 1'b0, 1'b1, 1'b1);
      write_entry(4'd1, 20'h00020, 8'd7, 1'b1, 20'h80020, 1'b1, 1'b0, 1'b1);
      write_entry(4'd2, 20'h00030, 8'd5, 1'b0, 20'h80030, 1'b0, 1'b0, 1'b0);
      write_entry(4'd3, 20'h00040, 8'd9, 1'b0, 20'h80040, 1'b0, 1'b1, 1'b1);

      for (int i = 0; i < NV; i++) begin
         logic [68:0] v;
         logic [31:0] prev_bad;
         v = VECS[i];
         prev_bad = bad_vaddr;
         lookup(v[68:37], v[36:35]);
         check($sformatf("R8 vector %0d rsp_valid", i), 32'(rsp_valid), 32'd1);
         check($sformatf("R3 R4 R5 vector %0d exception", i), 32'(rsp_exc), 32'(v[34:33]));
         check($sformatf("R1 vector %0d paddr", i), rsp_paddr, v[32:1]);
         check($sformatf("R7 vector %0d uncached", i), 32'(rsp_uncached), 32'(v[0]));
         check($sformatf("R6 vector %0d bad_vaddr", i), bad_vaddr,
               (v[34:33] != 2'd0) ? v[68:37] : prev_bad);
      end

      // R8 idle cycle
      @(negedge clk);
      check("R8 idle rsp_valid", 32'(rsp_valid), 32'd0);
      check("R6 bad_vaddr held over idle", bad_vaddr, 32'h1234_5678);

      // R12 ASID change in the same cycle as a lookup
      asid_wr_en = 1'b1; asid_wr_data = 8'd9;
      lookup(32'h0004_0555, 2'd1);
      asid_wr_en = 1'b0;
      check("R12 same-cycle lookup uses old ASID", 32'(rsp_exc), 32'd1);
      lookup(32'h0004_0555, 2'd1);
      check("R12 new ASID hit", rsp_paddr, 32'h8004_0555);
      lookup(32'h0001_0ABC, 2'd1);
      check("R2 old-ASID entry now misses", 32'(rsp_exc), 32'd1);
      lookup(32'h0002_0123, 2'd1);
      check("R2 global entry still hits", rsp_paddr, 32'h8002_0123);

      // R9 write and lookup in the same cycle
      wr_en = 1'b1; wr_idx = 4'd7; wr_vpn = 20'h00070; wr_asid = 8'd9; wr_global = 1'b0;
      wr_pfn = 20'h70070; wr_nocache = 1'b0; wr_dirty = 1'b1; wr_valid = 1'b1;
      lookup(32'h0007_0010, 2'd2);
      wr_en = 1'b0;
      check("R9 same-cycle lookup sees old contents", 32'(rsp_exc), 32'd1);
      lookup(32'h0007_0010, 2'd2);
      check("R9 written entry visible next cycle", rsp_paddr, 32'h7007_0010);
      check("R10 no multi-hit yet", 32'(multi_hit), 32'd0);

      // R10 duplicate mapping: lowest index wins, status sticky
      write_entry(4'd6, 20'h00040, 8'd9, 1'b0, 20'h90040, 1'b1, 1'b1, 1'b1);
      lookup(32'h0004_0001, 2'd0);
      check("R10 lowest index supplies frame", rsp_paddr, 32'h8004_0001);
      check("R10 lowest index supplies flags", 32'(rsp_uncached), 32'd0);
      check("R10 multi_hit set", 32'(multi_hit), 32'd1);
      lookup(32'h0007_0000, 2'd1);
      check("R10 multi_hit sticky", 32'(multi_hit), 32'd1);

      // R11 reset clears entries and status
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 multi_hit cleared by reset", 32'(multi_hit), 32'd0);
      check("R6 bad_vaddr cleared by reset", bad_vaddr, 32'd0);
      lookup(32'h0002_0123, 2'd0);
      check("R11 entries gone after reset", 32'(rsp_exc), 32'd1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule